// File: doc/BRIEF.md
# Debug Register Chain JTAG Master

This block is a JTAG master engine. It drives TCK, TMS and TDI and samples TDO, so that a host on the system clock can reach a target core's debug register bank. That bank sits behind scan chain 2. The host issues one request at a time on a valid/ready interface. A request carries a read/write flag, a 5-bit register address and, for writes, 32 bits of data. The engine first puts the target's TAP on chain 2. It then loads the test-mode instruction and runs the data-register scans. It finishes with a one-cycle done pulse, and for a read the data comes back on `rdata`.

The controller is a single enumerated state machine in which each state lasts a whole number of TCK bits. The states are:

- `ST_RESET`: TMS held high.
- `ST_RST_RTI`: one TMS-low bit into Run-Test/Idle.
- `ST_IDLE`: TCK stopped, ready high.
- `ST_HEAD`: the path from Run-Test/Idle or Update into Shift. It is 1,1,0,0 for an IR scan and 1,0,0 for a DR scan.
- `ST_SHIFT`: the payload bits, with TMS high on the last bit.
- `ST_UPDATE`: Exit1 to Update.
- `ST_TAIL`: Update to Run-Test/Idle.

A segment register selects one of six scans:

- `SEG_SELIR`: the chain-select instruction.
- `SEG_SELDR`: the chain number.
- `SEG_TSTIR`: the test-mode instruction.
- `SEG_WRDR`: the write scan.
- `SEG_RDADR`: the read address scan.
- `SEG_RDDDR`: the read data scan.

The transitions are:

- `ST_IDLE` goes to `ST_HEAD` when a request is accepted.
- `ST_HEAD` goes to `ST_SHIFT` and `ST_SHIFT` goes to `ST_UPDATE`.
- `ST_UPDATE` goes to `ST_HEAD` of the next segment while the chain is being selected, and to `ST_TAIL` after a register scan.
- `ST_TAIL` goes to `ST_HEAD` of `SEG_RDDDR` after the read address scan, and to `ST_IDLE` otherwise.
- `ST_RESET` goes to `ST_RST_RTI`, which goes to `ST_IDLE`.

Top module: `dbg_chain_jtag_master`

## Requirements
- R1: After reset the engine drives TMS high for at least 5 rising TCK edges, then one TMS-low bit, which leaves the TAP in Run-Test/Idle. It then raises `req_ready`. Reset also forgets the selected chain, so the next request selects the chain again.
- R2: TCK runs with a half period of `tck_half_m1`+1 system clocks, which is a full period of 2*(`tck_half_m1`+1). TCK is held low whenever `req_ready` is high.
- R3: TMS and TDI change only in the cycle in which TCK falls. TDO is sampled when TCK rises.
- R4: Instructions are 4 bits, shifted LSB first. The chain-select instruction is 4'b0010 and the test-mode instruction is 4'b1100. The chain number is a 4-bit value of 2, shifted LSB first in a DR scan.
- R5: The first request after reset performs four steps in order: chain-select IR scan, chain DR scan, test-mode IR scan, then the register scans. The TAP does not enter Run-Test/Idle between acceptance and the start of the first register scan.
- R6: Later requests skip the chain-select IR scan and the chain DR scan. Every request still loads the test-mode instruction once.
- R7: A write is one 38-bit DR scan. It carries 32 data bits LSB first, then the 5 address bits LSB first, then a final bit of 1.
- R8: A read is a 6-bit DR scan (5 address bits LSB first, then a 0) followed by a 32-bit DR scan. The bits from the second scan are captured from TDO in LSB-first order and returned on `rdata` with done.
- R9: Each register scan ends in Run-Test/Idle. A write enters Run-Test/Idle once per request and a read twice. The TAP is in Run-Test/Idle when done is high.
- R10: `req_ready` is high only while idle, so no request is taken while one is in flight. Done is high for exactly one cycle, and `req_ready` is already high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tck_half_m1 | input | 8 | TCK half period minus one, in system clocks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 5 | Debug register address |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid with done |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
The bench models the target TAP and a 32-entry register bank on chain 2. It counts IR loads, DR scan lengths and entries into Run-Test/Idle for each request.

It checks that the first request after each reset selects the chain without touching Run-Test/Idle. An engine that left Update through Run-Test/Idle would show an extra idle entry. An engine that kept its cached chain across reset would show no chain-select load.

Random reads and writes at addresses 0, 31 and random values test the bit order. A reversed field order or a wrong read/write bit corrupts the model's register or the returned word. A mis-timed TDO sample shifts the returned word by one bit. Changing the divider between requests exposes a wrong TCK period.

// File: rtl/dcj_pkg.sv
package dcj_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_RST_RTI,
        ST_IDLE,
        ST_HEAD,
        ST_SHIFT,
        ST_UPDATE,
        ST_TAIL
    } state_t;

    typedef enum logic [2:0] {
        SEG_SELIR,
        SEG_SELDR,
        SEG_TSTIR,
        SEG_WRDR,
        SEG_RDADR,
        SEG_RDDDR
    } seg_t;

endpackage

// File: rtl/dcj_tck_gen.sv
module dcj_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             tck,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             tck_q;
    logic             wrap;

    assign wrap = run && (cnt_q >= half_m1);
    assign rise = wrap && !tck_q;
    assign fall = wrap && tck_q;
    assign tck  = tck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tck_q <= !tck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dcj_capture.sv
module dcj_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (en) begin
            word <= {bit_in, word[W-1:1]};
        end
    end
endmodule

// File: rtl/dcj_seq.sv
module dcj_seq
    import dcj_pkg::*;
#(
    parameter int          ADDR_W    = 5,
    parameter int          DATA_W    = 32,
    parameter int          IR_W      = 4,
    parameter int          CHAIN_W   = 4,
    parameter int          RST_LEN   = 5,
    parameter logic [3:0]  IR_SELECT = 4'b0010,
    parameter logic [3:0]  IR_TEST   = 4'b1100,
    parameter logic [3:0]  CHAIN_ID  = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] cap_word,
    output logic              run,
    output logic              cap_en,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              tms,
    output logic              tdi
);
    localparam int WR_LEN = DATA_W + ADDR_W + 1;
    localparam int RA_LEN = ADDR_W + 1;
    localparam int CNT_W  = $clog2(WR_LEN + 1);

    state_t              state_q, state_d;
    seg_t                seg_q, seg_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                wr_q, wr_d;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic [DATA_W-1:0]   wdata_q, wdata_d;
    logic                cached_q, cached_d;
    logic                done_d;
    logic [DATA_W-1:0]   rdata_d;
    logic [CNT_W-1:0]    seg_last;
    logic [CNT_W-1:0]    head_last;
    logic                seg_ir;
    logic [WR_LEN-1:0]   payload;

    always_comb begin
        seg_ir  = 1'b0;
        payload = '0;
        unique case (seg_q)
            SEG_SELIR: begin seg_ir = 1'b1; seg_last = CNT_W'(IR_W - 1);    payload[IR_W-1:0]    = IR_SELECT; end
            SEG_SELDR: begin                seg_last = CNT_W'(CHAIN_W - 1); payload[CHAIN_W-1:0] = CHAIN_ID;  end
            SEG_TSTIR: begin seg_ir = 1'b1; seg_last = CNT_W'(IR_W - 1);    payload[IR_W-1:0]    = IR_TEST;   end
            SEG_WRDR:  begin                seg_last = CNT_W'(WR_LEN - 1);  payload = {1'b1, addr_q, wdata_q}; end
            SEG_RDADR: begin                seg_last = CNT_W'(RA_LEN - 1);  payload[RA_LEN-1:0] = {1'b0, addr_q}; end
            default:   begin                seg_last = CNT_W'(DATA_W - 1); end
        endcase
        head_last = seg_ir ? CNT_W'(3) : CNT_W'(2);
    end

    // next-state and datapath load
    always_comb begin
        state_d  = state_q;
        seg_d    = seg_q;
        cnt_d    = cnt_q;
        wr_d     = wr_q;
        addr_d   = addr_q;
        wdata_d  = wdata_q;
        cached_d = cached_q;
        done_d   = 1'b0;
        rdata_d  = rdata;
        unique case (state_q)
            ST_RESET: if (fall) begin
                if (cnt_q == CNT_W'(RST_LEN - 1)) begin
                    state_d = ST_RST_RTI;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RST_RTI: if (fall) state_d = ST_IDLE;
            ST_IDLE: if (req_valid) begin
                wr_d    = req_write;
                addr_d  = req_addr;
                wdata_d = req_wdata;
                seg_d   = cached_q ? SEG_TSTIR : SEG_SELIR;
                state_d = ST_HEAD;
                cnt_d   = '0;
            end
            ST_HEAD: if (fall) begin
                if (cnt_q == head_last) begin
                    state_d = ST_SHIFT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SHIFT: if (fall) begin
                if (cnt_q == seg_last) state_d = ST_UPDATE;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            ST_UPDATE: if (fall) begin
                cnt_d = '0;
                unique case (seg_q)
                    SEG_SELIR: begin seg_d = SEG_SELDR; state_d = ST_HEAD; end
                    SEG_SELDR: begin seg_d = SEG_TSTIR; state_d = ST_HEAD; cached_d = 1'b1; end
                    SEG_TSTIR: begin seg_d = wr_q ? SEG_WRDR : SEG_RDADR; state_d = ST_HEAD; end
                    default:   state_d = ST_TAIL;
                endcase
            end
            ST_TAIL: if (fall) begin
                cnt_d = '0;
                if (seg_q == SEG_RDADR) begin
                    seg_d   = SEG_RDDDR;
                    state_d = ST_HEAD;
                end else begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                    if (seg_q == SEG_RDDDR) rdata_d = cap_word;
                end
            end
            default: state_d = ST_RESET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_RESET;
            seg_q    <= SEG_SELIR;
            cnt_q    <= '0;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            cached_q <= 1'b0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            state_q  <= state_d;
            seg_q    <= seg_d;
            cnt_q    <= cnt_d;
            wr_q     <= wr_d;
            addr_q   <= addr_d;
            wdata_q  <= wdata_d;
            cached_q <= cached_d;
            done     <= done_d;
            rdata    <= rdata_d;
        end
    end

    // pin outputs
    always_comb begin
        tdi = 1'b0;
        unique case (state_q)
            ST_RESET:   tms = 1'b1;
            ST_RST_RTI: tms = 1'b0;
            ST_IDLE:    tms = 1'b1;
            ST_HEAD:    tms = seg_ir ? (cnt_q < CNT_W'(2)) : (cnt_q == '0);
            ST_SHIFT: begin
                tms = (cnt_q == seg_last);
                tdi = payload[cnt_q];
            end
            ST_UPDATE:  tms = 1'b1;
            ST_TAIL:    tms = 1'b0;
            default:    tms = 1'b1;
        endcase
    end

    assign run       = (state_q != ST_IDLE);
    assign req_ready = (state_q == ST_IDLE);
    assign cap_en    = rise && (state_q == ST_SHIFT) && (seg_q == SEG_RDDDR);
endmodule

// File: rtl/dbg_chain_jtag_master.sv
module dbg_chain_jtag_master #(
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  tck_half_m1,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    logic              run;
    logic              rise;
    logic              fall;
    logic              cap_en;
    logic [DATA_W-1:0] cap_word;

    dcj_tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk(clk), .rst_n(rst_n), .run(run), .half_m1(tck_half_m1),
        .tck(tck), .rise(rise), .fall(fall)
    );

    dcj_capture #(.W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .en(cap_en), .bit_in(tdo), .word(cap_word)
    );

    dcj_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .cap_word(cap_word), .run(run), .cap_en(cap_en),
        .req_ready(req_ready), .done(done), .rdata(rdata), .tms(tms), .tdi(tdi)
    );
endmodule

// File: rtl/dcj_checker.sv
module dcj_checker (
    input logic clk,
    input logic rst_n,
    input logic tck,
    input logic tms,
    input logic tdi,
    input logic done,
    input logic req_ready
);
    // R3
    tms_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> $fell(tck));

    // R3
    tdi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdi) |-> $fell(tck));

    // R2
    idle_tck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tck);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

bind dbg_chain_jtag_master dcj_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .done(done), .req_ready(req_ready)
);

// File: tb/dbg_chain_jtag_master_tb.sv
module dbg_chain_jtag_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    // TAP state codes of the bench model
    localparam int TLR = 0,  RTI = 1,  SDR = 2,  CDR = 3,  SHD = 4,  E1D = 5,  PDR = 6,  E2D = 7;
    localparam int UDR = 8,  SIR = 9,  CIR = 10, SHI = 11, E1I = 12, PIR = 13, E2I = 14, UIR = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tck_half_m1 = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic        tck, tms, tdi;
    logic        tdo = 1'b0;

    int tests = 0, fails = 0, cyc = 0;

    // target model state
    int          tap = SHI;
    logic [3:0]  ir = 4'd0, ir_sr = 4'd0, chain = 4'd0;
    logic [63:0] dr_in = '0;
    int          dr_len = 0;
    logic [31:0] out_sr = '0;
    logic [31:0] regs [32];
    logic [31:0] shadow [32];
    logic        rd_pend = 1'b0;
    logic [4:0]  rd_addr = '0;
    int          sel_cnt = 0, tst_cnt = 0, rti_cnt = 0, dr_cnt = 0;
    int          dr_lens [8];
    int          ones_run = 0;
    logic        seen_zero = 1'b0;
    int          last_rise = 0, rises = 0, period = 0;

    dbg_chain_jtag_master u_dut (
        .clk(clk), .rst_n(rst_n), .tck_half_m1(tck_half_m1),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    function automatic int tap_next(int s, logic m);
        case (s)
            TLR: return m ? TLR : RTI;
            RTI: return m ? SDR : RTI;
            SDR: return m ? SIR : CDR;
            CDR: return m ? E1D : SHD;
            SHD: return m ? E1D : SHD;
            E1D: return m ? UDR : PDR;
            PDR: return m ? E2D : PDR;
            E2D: return m ? UDR : SHD;
            UDR: return m ? SDR : RTI;
            SIR: return m ? TLR : CIR;
            CIR: return m ? E1I : SHI;
            SHI: return m ? E1I : SHI;
            E1I: return m ? UIR : PIR;
            PIR: return m ? E2I : PIR;
            E2I: return m ? UIR : SHI;
            default: return m ? SDR : RTI;
        endcase
    endfunction

    always @(posedge tck) begin : tap_model
        logic [63:0] v;
        int nxt;
        if (rises > 0) period = cyc - last_rise;
        last_rise = cyc;
        rises++;
        if (!seen_zero) begin
            if (tms) ones_run++;
            else     seen_zero = 1'b1;
        end
        case (tap)
            SHI: ir_sr = {tdi, ir_sr[3:1]};
            SHD: begin
                dr_in  = {tdi, dr_in[63:1]};
                dr_len++;
                out_sr = out_sr >> 1;
            end
            CDR: begin
                dr_len = 0;
                dr_in  = '0;
                out_sr = (ir == 4'b1100 && chain == 4'd2 && rd_pend) ? regs[rd_addr] : 32'd0;
            end
            UIR: begin
                ir = ir_sr;
                if (ir_sr == 4'b0010) sel_cnt++;
                if (ir_sr == 4'b1100) tst_cnt++;
            end
            UDR: begin
                v = dr_in >> (64 - dr_len);
                if (dr_cnt < 8) dr_lens[dr_cnt] = dr_len;
                dr_cnt++;
                if (ir == 4'b0010) chain = v[3:0];
                else if (ir == 4'b1100 && chain == 4'd2) begin
                    if (dr_len == 38 && v[37]) regs[v[36:32]] = v[31:0];
                    if (dr_len == 6 && !v[5]) begin
                        rd_pend = 1'b1;
                        rd_addr = v[4:0];
                    end
                end
            end
            default: ;
        endcase
        nxt = tap_next(tap, tms);
        if (nxt == RTI && tap != RTI) rti_cnt++;
        tap = nxt;
    end

    always @(negedge tck) tdo = out_sr[0];

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        ones_run  = 0;
        seen_zero = 1'b0;
        rst_n     = 1'b1;
        while (!req_ready) @(negedge clk);
        // R1: TAP parked in Run-Test/Idle after the TMS-high run
        check(tap == RTI, "R1 tap state after reset", 32'(tap), 32'(RTI));
        check(ones_run >= 5, "R1 TMS-high bits", 32'(ones_run), 32'd5);
        check(tck == 1'b0 && done == 1'b0, "R2/R10 idle outputs", {30'd0, tck, done}, 32'd0);
    endtask

    task automatic do_op(input logic wr, input logic [4:0] a, input logic [31:0] d, input logic expect_sel);
        int s0, t0, r0;
        logic [31:0] got;
        while (!req_ready) @(negedge clk);
        s0 = sel_cnt; t0 = tst_cnt; r0 = rti_cnt;
        dr_cnt = 0; rises = 0; period = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10 ready low while busy", {31'd0, req_ready}, 32'd0);
        while (!done) @(negedge clk);
        got = rdata;
        check(tap == RTI, "R9 tap in idle at done", 32'(tap), 32'(RTI));
        check(req_ready == 1'b1, "R10 ready with done", {31'd0, req_ready}, 32'd1);
        // R5 / R6: chain selection only when needed, test instruction always
        check((sel_cnt - s0) == (expect_sel ? 1 : 0), expect_sel ? "R5 chain select loaded" : "R6 chain select skipped",
              32'(sel_cnt - s0), expect_sel ? 32'd1 : 32'd0);
        check((tst_cnt - t0) == 1, "R6 test instruction loaded once", 32'(tst_cnt - t0), 32'd1);
        // R9 / R5: Run-Test/Idle entries, none during chain selection
        check((rti_cnt - r0) == (wr ? 1 : 2), "R9/R5 idle entries", 32'(rti_cnt - r0), wr ? 32'd1 : 32'd2);
        check(period == 2 * (int'(tck_half_m1) + 1), "R2 TCK period", 32'(period), 32'(2 * (int'(tck_half_m1) + 1)));
        if (wr) begin
            shadow[a] = d;
            check(dr_cnt == (expect_sel ? 2 : 1) && dr_lens[dr_cnt-1] == 38, "R7 write scan length",
                  32'(dr_lens[dr_cnt-1]), 32'd38);
            check(regs[a] == d, "R7 register written", regs[a], d);
            if (expect_sel)
                check(dr_lens[0] == 4 && chain == 4'd2, "R4 chain scan", {28'd0, chain}, 32'd2);
        end else begin
            check(dr_cnt >= 2 && dr_lens[dr_cnt-2] == 6 && dr_lens[dr_cnt-1] == 32, "R8 read scan lengths",
                  32'(dr_lens[dr_cnt-2]), 32'd6);
            check(got == shadow[a], "R8 read data", got, shadow[a]);
            if (expect_sel)
                check(dr_lens[0] == 4 && chain == 4'd2, "R4 chain scan", {28'd0, chain}, 32'd2);
        end
        @(negedge clk);
        check(done == 1'b0, "R10 done single cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin : main
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < 32; i++) begin
            regs[i]   = $urandom;
            shadow[i] = regs[i];
        end
        do_reset();
        // R5/R7: first write selects the chain
        do_op(1'b1, 5'd3, 32'hA5C3_0F81, 1'b1);
        // corner addresses and patterns
        tck_half_m1 = 8'd0;
        do_op(1'b1, 5'd0, 32'hFFFF_FFFF, 1'b0);
        do_op(1'b1, 5'd31, 32'h8000_0001, 1'b0);
        do_op(1'b0, 5'd0, 32'd0, 1'b0);
        do_op(1'b0, 5'd31, 32'd0, 1'b0);
        do_op(1'b0, 5'd3, 32'd0, 1'b0);
        for (int n = 0; n < 40; n++) begin
            tck_half_m1 = 8'($urandom_range(0, 3));
            do_op(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), $urandom, 1'b0);
        end
        // R1: reset forgets the chain, so the next request selects it again
        tap = SHD;
        do_reset();
        tck_half_m1 = 8'd2;
        do_op(1'b0, 5'd17, 32'd0, 1'b1);
        do_op(1'b0, 5'd31, 32'd0, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule